// File: doc/BRIEF.md
# Pad Interrupt Router with Input Filter

This block watches a wide bank of pad input lines and steers any eight of them onto eight interrupt outputs. Each output channel owns a source selector, a programmable stability filter, a choice between level and edge sensing, and an inversion control. The inversion is applied before sensing. As a result, every output is active-high, and a downstream interrupt controller that only accepts high levels and rising edges can still serve low-level and falling-edge sources.

Software programs four 32-bit configuration words through a simple word-addressed write/read port. Pads pass through a two-stage synchroniser before selection. Any change to a channel's sensing, inversion or source re-seeds that channel's history, so a reconfiguration never produces a false event. Deciding which pad goes to which channel is left to software.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, all four configuration words read as zero and every output is low. In that state each channel is an active-high level channel on pad 0 with no filtering.
- R2: Word 0 (cfg_addr 0) holds the per-channel controls. Bit c set selects edge sensing for channel c. Bit 16+c set selects inversion, meaning low level or falling edge. Bits 15:8 and 31:24 are not stored and read as zero.
- R3: Word 1 holds the 8-bit source selects of channels 0 to 3, and word 2 holds those of channels 4 to 7. The field of channel c sits at bit (c mod 4)*8. A selected pad reaches its channel output four clock edges after the pad changes.
- R4: A select value at or above NUM_PADS routes a constant zero into the channel. This holds at the boundary value NUM_PADS and at 255. The value NUM_PADS-1 still routes its pad.
- R5: In level mode without inversion, the output follows the selected pad as a high level.
- R6: With inversion set in level mode, the output is high while the selected pad is low.
- R7: In rising-edge mode, the output is high for exactly one cycle per rising edge. It stays low while the pad holds high and when the pad falls.
- R8: In falling-edge mode (edge and inversion both set), each falling edge gives one single-cycle high pulse and a rising edge gives none.
- R9: Word 3 holds a 4-bit filter value per channel at bit c*4. A value N>0 requires the selected input to differ from the filtered state for N*4 consecutive cycles before the filtered state follows. Shorter glitches are dropped. N=0 bypasses the filter.
- R10: Writing a word that changes a channel's sensing, inversion or source clears that channel's edge and filter history. No pulse results from the reconfiguration itself.
- R11: Several channels may select the same pad. Each channel then applies its own sensing independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pad_in | input | NUM_PADS | Asynchronous pad lines |
| cfg_we | input | 1 | Write strobe for the configuration word at cfg_addr |
| cfg_addr | input | 2 | Word index (byte offset divided by four) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the word at cfg_addr, combinational |
| irq_o | output | 8 | Active-high interrupt outputs, one per channel |

## Verification
A configuration write and a live input transition can meet in the same cycle on one channel. This happens when a channel in edge mode is switched to a pad that is already high, or when its inversion is flipped while the pad is steady, because without the history re-seed either change would look like a new edge. The bench provokes both cases and then watches the output on every cycle of a window, expecting no pulse. Afterwards it drives a real edge and expects the pulse at its normal cycle. Two channels that share one pad but sense it differently are also checked in the same cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NCH     = 8;
  localparam int SEL_W   = 8;
  localparam int FILT_W  = 4;
  localparam int DATA_W  = 32;
  localparam int INV_POS = 16;
  localparam int HALF    = NCH / 2;

  typedef enum logic [1:0] {
    W_MODE   = 2'd0,
    W_SEL_LO = 2'd1,
    W_SEL_HI = 2'd2,
    W_FILT   = 2'd3
  } word_idx_e;

  typedef struct packed {
    logic              edge_en;
    logic              inv;
    logic [SEL_W-1:0]  sel;
    logic [FILT_W-1:0] filt;
  } ch_cfg_t;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output ch_cfg_t [NCH-1:0]    cfg,
  output logic [NCH-1:0]       clr
);
  logic [NCH-1:0]             edge_q, edge_d, inv_q, inv_d, chg, clr_q;
  logic [NCH-1:0][SEL_W-1:0]  sel_q, sel_d;
  logic [NCH-1:0][FILT_W-1:0] filt_q, filt_d;

  always_comb begin
    edge_d = edge_q;
    inv_d  = inv_q;
    sel_d  = sel_q;
    filt_d = filt_q;
    if (we) begin
      case (word_idx_e'(addr))
        W_MODE: begin
          edge_d = wdata[NCH-1:0];
          inv_d  = wdata[INV_POS +: NCH];
        end
        W_SEL_LO: for (int c = 0; c < HALF; c++) sel_d[c] = wdata[c*SEL_W +: SEL_W];
        W_SEL_HI: for (int c = 0; c < HALF; c++) sel_d[c+HALF] = wdata[c*SEL_W +: SEL_W];
        default:  for (int c = 0; c < NCH; c++) filt_d[c] = wdata[c*FILT_W +: FILT_W];
      endcase
    end
    for (int c = 0; c < NCH; c++)
      chg[c] = (edge_d[c] != edge_q[c]) || (inv_d[c] != inv_q[c]) || (sel_d[c] != sel_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      inv_q  <= '0;
      sel_q  <= '0;
      filt_q <= '0;
      clr_q  <= '0;
    end else begin
      edge_q <= edge_d;
      inv_q  <= inv_d;
      sel_q  <= sel_d;
      filt_q <= filt_d;
      clr_q  <= chg;
    end
  end

  always_comb begin
    rdata = '0;
    case (word_idx_e'(addr))
      W_MODE: begin
        rdata[NCH-1:0]        = edge_q;
        rdata[INV_POS +: NCH] = inv_q;
      end
      W_SEL_LO: rdata = sel_q[HALF-1:0];
      W_SEL_HI: rdata = sel_q[NCH-1:HALF];
      default:  rdata = filt_q;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cfg
    assign cfg[c] = '{edge_en: edge_q[c], inv: inv_q[c], sel: sel_q[c], filt: filt_q[c]};
  end
  assign clr = clr_q;

  // R10
  sel_chg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd1 && wdata[SEL_W-1:0] != sel_q[0]) |=> clr[0]);
endmodule

// File: rtl/pirq_channel.sv
module pirq_channel
  import pirq_pkg::*;
#(
  parameter int NUM_PADS   = 133,
  parameter int FILT_SCALE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_s,
  input  ch_cfg_t             cfg,
  input  logic                clr,
  output logic                irq
);
  localparam int CNT_W = $clog2(((1 << FILT_W) - 1) * FILT_SCALE + 1);

  logic             sel_bit, in_v;
  logic             flt_q, flt_d, prev_q, prev_d, irq_q, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < NUM_PADS; i++)
      if (cfg.sel == SEL_W'(i)) sel_bit = pads_s[i];
  end

  assign in_v   = sel_bit ^ cfg.inv;
  assign lim_m1 = CNT_W'(cfg.filt) * CNT_W'(FILT_SCALE) - CNT_W'(1);

  always_comb begin
    flt_d  = flt_q;
    cnt_d  = cnt_q;
    prev_d = flt_q;
    irq_d  = cfg.edge_en ? (flt_q & ~prev_q) : flt_q;
    if (clr) begin
      flt_d  = in_v;
      prev_d = in_v;
      cnt_d  = '0;
      irq_d  = 1'b0;
    end else if (cfg.filt == '0 || in_v == flt_q) begin
      flt_d = in_v;
      cnt_d = '0;
    end else if (cnt_q == lim_m1) begin
      flt_d = in_v;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      flt_q  <= flt_d;
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

  // R7
  edge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.edge_en && irq_q && !clr) |=> !irq_q);

  // R10
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_q);

  // R9
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr && cfg.filt != '0) && flt_q != $past(flt_q)) |-> $past(cnt_q) == $past(lim_m1));
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pirq_pkg::*;
#(
  parameter int NUM_PADS   = 133,
  parameter int FILT_SCALE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic [NCH-1:0]      irq_o
);
  logic                rst_meta_q, rst_int_n;
  logic [NUM_PADS-1:0] pads_s;
  ch_cfg_t [NCH-1:0]   cfg;
  logic [NCH-1:0]      clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  pirq_sync #(.W(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(pad_in), .d_sync(pads_s)
  );

  pirq_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg), .clr(clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pirq_channel #(.NUM_PADS(NUM_PADS), .FILT_SCALE(FILT_SCALE)) u_ch (
      .clk(clk), .rst_n(rst_int_n), .pads_s(pads_s),
      .cfg(cfg[c]), .clr(clr[c]), .irq(irq_o[c])
    );
  end
endmodule

// File: tb/tb_pad_irq_router.sv
`timescale 1ns/1ps
module tb_pad_irq_router;
  localparam int NP = 133;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pads;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [7:0]    irq;
  int            n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  pad_irq_router #(.NUM_PADS(NP), .FILT_SCALE(4)) dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pads), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic clean();
    pads = '0;
    for (int a = 0; a < 4; a++) wr(2'(a), 32'h0);
    tick(6);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 4; a++) rd_chk("R1 reset word", 2'(a), 32'h0);
    chk("R1 reset irq", {24'h0, irq}, 32'h0);
  endtask

  task automatic t_regmap();
    wr(0, 32'hFFFF_FFFF); rd_chk("R2 mode word unused bits", 0, 32'h00FF_00FF);
    wr(1, 32'h1122_3344); rd_chk("R3 sel lo", 1, 32'h1122_3344);
    wr(2, 32'hA5A5_5A5A); rd_chk("R3 sel hi", 2, 32'hA5A5_5A5A);
    wr(3, 32'h1234_5678); rd_chk("R9 filt word", 3, 32'h1234_5678);
    clean();
  endtask

  task automatic t_route();
    wr(1, 32'h000A_0000);
    wr(2, 32'h0000_6400);
    tick(4);
    pads[10] = 1'b1;
    tick(3); chk("R3 latency before", {24'h0, irq}, 32'h00);
    tick(1); chk("R5 ch2 high", {24'h0, irq}, 32'h04);
    pads[100] = 1'b1;
    tick(4); chk("R3 ch5 routed", {24'h0, irq}, 32'h24);
    pads[10] = 1'b0;
    tick(4); chk("R5 ch2 follows low", {24'h0, irq}, 32'h20);
    clean();
  endtask

  task automatic t_oor();
    wr(1, 32'h0000_8500);
    wr(2, 32'h0000_0084);
    pads = '1;
    tick(6); chk("R4 sel=NUM_PADS zero, NUM_PADS-1 routed", {24'h0, irq}, 32'hFD);
    wr(1, 32'h0000_FF00);
    tick(6); chk("R4 sel=255 zero", {24'h0, irq}, 32'hFD);
    clean();
  endtask

  task automatic t_low();
    wr(1, 32'h0700_0000);
    wr(0, 32'h0008_0000);
    tick(6); chk("R6 low pad gives high", {24'h0, irq}, 32'h08);
    pads[7] = 1'b1;
    tick(3); chk("R6 before latency", {24'h0, irq}, 32'h08);
    tick(1); chk("R6 high pad gives low", {24'h0, irq}, 32'h00);
    clean();
  endtask

  task automatic t_rise();
    wr(1, 32'h0000_0005);
    wr(0, 32'h0000_0001);
    tick(6); chk("R7 idle", {24'h0, irq}, 32'h0);
    pads[5] = 1'b1;
    tick(3); chk("R7 before pulse", {24'h0, irq}, 32'h0);
    tick(1); chk("R7 pulse", {24'h0, irq}, 32'h1);
    tick(1); chk("R7 pulse ends", {24'h0, irq}, 32'h0);
    tick(5); chk("R7 held high no pulse", {24'h0, irq}, 32'h0);
    pads[5] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1); chk("R7 fall no pulse", {24'h0, irq}, 32'h0);
    end
    pads[5] = 1'b1;
    tick(4); chk("R7 second pulse", {24'h0, irq}, 32'h1);
    tick(1); chk("R7 second pulse ends", {24'h0, irq}, 32'h0);
    clean();
  endtask

  task automatic t_fall();
    wr(2, 32'h0009_0000);
    wr(0, 32'h0040_0040);
    tick(6); chk("R8 idle", {24'h0, irq}, 32'h0);
    pads[9] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick(1); chk("R8 rise no pulse", {24'h0, irq}, 32'h0);
    end
    pads[9] = 1'b0;
    tick(3); chk("R8 before pulse", {24'h0, irq}, 32'h0);
    tick(1); chk("R8 falling pulse", {24'h0, irq}, 32'h40);
    tick(1); chk("R8 pulse ends", {24'h0, irq}, 32'h0);
    clean();
  endtask

  task automatic t_filter();
    wr(3, 32'h0002_0000);
    wr(2, 32'h0000_0014);
    rd_chk("R9 filt field ch4", 3, 32'h0002_0000);
    tick(6);
    pads[20] = 1'b1;
    tick(6);
    pads[20] = 1'b0;
    for (int i = 0; i < 14; i++) begin
      tick(1); chk("R9 glitch dropped", {24'h0, irq}, 32'h0);
    end
    pads[20] = 1'b1;
    tick(10); chk("R9 rise held back", {24'h0, irq}, 32'h00);
    tick(1);  chk("R9 rise after 4N", {24'h0, irq}, 32'h10);
    pads[20] = 1'b0;
    tick(10); chk("R9 fall held back", {24'h0, irq}, 32'h10);
    tick(1);  chk("R9 fall after 4N", {24'h0, irq}, 32'h00);
    clean();
  endtask

  task automatic t_reconf();
    pads[6] = 1'b1;
    wr(1, 32'h0000_0005);
    wr(0, 32'h0000_0001);
    tick(6); chk("R10 idle", {24'h0, irq}, 32'h0);
    wr(1, 32'h0000_0006);
    for (int i = 0; i < 8; i++) begin
      tick(1); chk("R10 sel switch no pulse", {24'h0, irq}, 32'h0);
    end
    pads[6] = 1'b0;
    tick(6); chk("R10 fall in rise mode", {24'h0, irq}, 32'h0);
    wr(0, 32'h0001_0001);
    for (int i = 0; i < 8; i++) begin
      tick(1); chk("R10 polarity flip no pulse", {24'h0, irq}, 32'h0);
    end
    pads[6] = 1'b1;
    tick(6); chk("R10 rise in fall mode", {24'h0, irq}, 32'h0);
    pads[6] = 1'b0;
    tick(4); chk("R10 real edge after reconfig", {24'h0, irq}, 32'h1);
    clean();
  endtask

  task automatic t_multi();
    wr(1, 32'h0000_0003);
    wr(2, 32'h0300_0000);
    wr(0, 32'h0000_0080);
    tick(6);
    pads[3] = 1'b1;
    tick(4); chk("R11 shared pad both", {24'h0, irq}, 32'h81);
    tick(1); chk("R11 level stays edge ends", {24'h0, irq}, 32'h01);
    clean();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pads = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_regmap();
    t_route();
    t_oor();
    t_low();
    t_rise();
    t_fall();
    t_filter();
    t_reconf();
    t_multi();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule